// File: doc/BRIEF.md
# Battery Voltage Negative-Slope Detector

This block watches a charging battery for the small fall in terminal voltage that marks full charge. An external voltage-to-frequency converter delivers a pulse stream whose rate is proportional to the sensed voltage. An external sample timer raises a gate window and then a one-cycle convert strobe once per sample period. The block counts the pulses that fall inside the window into a saturating 10-bit value. On the convert strobe it classifies that value against a ratcheting peak, which only ever moves up.

Two drop samples in a row assert the latched full-charge output. Detection is armed only after fast-charge mode has been active for a start delay. The output cannot be set during a holdoff that is counted in evaluated samples. A drop seen during holdoff is cancelled if a later sample climbs back above the peak. An undervoltage indication or the asynchronous reset clears all of the detection state, including the latched output.

Top module: `nslope_detector`

## Requirements
- R1: After rst_ni is released, full_o is 0.
- R2: The sample value is the number of clock cycles with both gate_i and pulse_i high since the previous convert strobe, saturating at 1023. Pulses while gate_i is low are not counted.
- R3: A convert strobe is evaluated only when fast_i has been high for at least START_CYC consecutive cycles before it. fast_i low for any cycle clears the arm delay, the peak, the drop run and the holdoff count, but leaves full_o unchanged.
- R4: The first evaluated sample loads the peak. Any later sample greater than the peak replaces it and clears the drop run.
- R5: An evaluated sample is a drop when it is at least 2 counts below the peak. A sample 0 or 1 count below the peak is not a drop.
- R6: An evaluated sample that is not a drop clears the run of consecutive drops.
- R7: The first HOLD_SAMPLES evaluated samples after arming can never set full_o. Drops among them still extend the drop run.
- R8: A drop run that started during holdoff is cancelled by a later sample above the peak, and full_o then stays 0.
- R9: full_o rises in the cycle after a convert strobe whose sample is the second consecutive drop, provided holdoff had already expired before that sample. It then stays 1 until cleared.
- R10: sense_low_i high on a clock edge clears full_o and all detection state, synchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Converter pulse, one count per high cycle |
| gate_i | input | 1 | Sample window; pulses counted while high |
| convert_i | input | 1 | One-cycle strobe that evaluates the sample |
| fast_i | input | 1 | Fast-charge mode active |
| sense_low_i | input | 1 | Sensed voltage below undervoltage threshold; clears detector |
| full_o | output | 1 | Latched full-charge (negative slope) indication |

## Verification
Fixed directed sequences separate the cases that the peak comparison must tell apart. A one-count dip must stay silent while a two-count dip counts as a drop. Two isolated drops with a non-drop between them must not fire, and two adjacent drops must. A drop pair that lands inside holdoff must wait for the first sample after holdoff, while a pair that a rise cancels must never fire. A saturating sample over 1023 pulses, with stray pulses outside the gate, shows whether the count wraps or leaks. Seeded random walks around random levels then compare every evaluated sample against a bench model of the peak, the drop run and the holdoff.

// File: rtl/nslope_pkg.sv
package nslope_pkg;
  localparam int unsigned CNT_W_DEF    = 10;
  localparam int unsigned DROP_MIN_DEF = 2;
  localparam int unsigned EVENTS_DEF   = 2;

  typedef enum logic [1:0] {
    SMP_LOAD = 2'd0,
    SMP_RISE = 2'd1,
    SMP_DROP = 2'd2,
    SMP_FLAT = 2'd3
  } smp_kind_e;
endpackage

// File: rtl/nslope_pulse_cnt.sv
module nslope_pulse_cnt #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             gate_i,
  input  logic             pulse_i,
  input  logic             convert_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_q <= '0;
    else if (clr_i || convert_i)                   cnt_q <= '0;
    else if (gate_i && pulse_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R2
  no_count_outside_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && !convert_i && !clr_i) |=> $stable(cnt_q));

  // R2
  cnt_saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !convert_i && !clr_i) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/nslope_arm_timer.sv
module nslope_arm_timer #(
  parameter int unsigned START_CYC    = 24,
  parameter int unsigned HOLD_SAMPLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sample_i,
  output logic armed_o,
  output logic hold_done_o
);
  localparam int unsigned SW = (START_CYC < 1) ? 1 : $clog2(START_CYC + 1);
  localparam int unsigned HW = (HOLD_SAMPLES < 1) ? 1 : $clog2(HOLD_SAMPLES + 1);
  localparam logic [SW-1:0] START_LIM = SW'(START_CYC);
  localparam logic [HW-1:0] HOLD_LIM  = HW'(HOLD_SAMPLES);

  logic [SW-1:0] start_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 start_q <= '0;
    else if (clr_i)              start_q <= '0;
    else if (start_q != START_LIM) start_q <= start_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          hold_q <= '0;
    else if (clr_i)                       hold_q <= '0;
    else if (sample_i && hold_q != HOLD_LIM) hold_q <= hold_q + 1'b1;
  end

  assign armed_o     = (start_q == START_LIM);
  assign hold_done_o = (hold_q == HOLD_LIM);

  // R3
  clear_disarms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (hold_q == '0) && (start_q == '0));

  // R7
  hold_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_done_o && !clr_i) |=> hold_done_o);
endmodule

// File: rtl/nslope_peak_trk.sv
module nslope_peak_trk
  import nslope_pkg::*;
#(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned DROP_MIN = 2,
  parameter int unsigned EVENTS   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             eval_i,
  input  logic [CNT_W-1:0] sample_i,
  output logic             event_o
);
  localparam int unsigned EW = (EVENTS < 1) ? 1 : $clog2(EVENTS + 1);
  localparam logic [EW-1:0]    RUN_MAX  = EW'(EVENTS);
  localparam logic [EW-1:0]    RUN_FIRE = EW'(EVENTS - 1);
  localparam logic [CNT_W-1:0] DIP_MIN  = CNT_W'(DROP_MIN);

  logic [CNT_W-1:0] peak_q;
  logic             vld_q;
  logic [EW-1:0]    run_q;
  smp_kind_e        kind;

  always_comb begin
    if (!vld_q)                             kind = SMP_LOAD;
    else if (sample_i > peak_q)             kind = SMP_RISE;
    else if ((peak_q - sample_i) >= DIP_MIN) kind = SMP_DROP;
    else                                    kind = SMP_FLAT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_q <= '0;
      vld_q  <= 1'b0;
      run_q  <= '0;
    end else if (clr_i) begin
      peak_q <= '0;
      vld_q  <= 1'b0;
      run_q  <= '0;
    end else if (eval_i) begin
      unique case (kind)
        SMP_LOAD, SMP_RISE: begin
          peak_q <= sample_i;
          vld_q  <= 1'b1;
          run_q  <= '0;
        end
        SMP_DROP: if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
        default:  run_q <= '0;
      endcase
    end
  end

  assign event_o = eval_i && (kind == SMP_DROP) && (run_q >= RUN_FIRE);

  // R4
  peak_ratchet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !clr_i) |=> peak_q >= $past(peak_q));

  // R6
  flat_clears_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !clr_i && kind == SMP_FLAT) |=> run_q == '0);

  // R5
  event_needs_dip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> (vld_q && (sample_i + DIP_MIN <= peak_q)));
endmodule

// File: rtl/nslope_detector.sv
module nslope_detector
  import nslope_pkg::*;
#(
  parameter int unsigned CNT_W        = CNT_W_DEF,
  parameter int unsigned START_CYC    = 24,
  parameter int unsigned HOLD_SAMPLES = 3,
  parameter int unsigned DROP_MIN     = DROP_MIN_DEF,
  parameter int unsigned EVENTS       = EVENTS_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic gate_i,
  input  logic convert_i,
  input  logic fast_i,
  input  logic sense_low_i,
  output logic full_o
);
  logic [CNT_W-1:0] cnt;
  logic             armed, hold_done, eval, det_clr, drop_event;
  logic             full_q;

  assign det_clr = sense_low_i || !fast_i;
  assign eval    = convert_i && armed && !det_clr;

  nslope_pulse_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (sense_low_i),
    .gate_i   (gate_i),
    .pulse_i  (pulse_i),
    .convert_i(convert_i),
    .cnt_o    (cnt)
  );

  nslope_arm_timer #(.START_CYC(START_CYC), .HOLD_SAMPLES(HOLD_SAMPLES)) u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (det_clr),
    .sample_i   (eval),
    .armed_o    (armed),
    .hold_done_o(hold_done)
  );

  nslope_peak_trk #(.CNT_W(CNT_W), .DROP_MIN(DROP_MIN), .EVENTS(EVENTS)) u_peak (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (det_clr),
    .eval_i  (eval),
    .sample_i(cnt),
    .event_o (drop_event)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       full_q <= 1'b0;
    else if (sense_low_i)              full_q <= 1'b0;
    else if (drop_event && hold_done)  full_q <= 1'b1;
  end

  assign full_o = full_q;

  // R9
  full_latched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !sense_low_i) |=> full_q);

  // R7
  full_after_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> $past(hold_done && convert_i && fast_i));

  // R10
  sense_low_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_low_i |=> !full_q);

  // R3
  fast_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fast_i |=> $stable(full_q) || !full_q);
endmodule

// File: tb/sim_nslope_detector.sv
module sim_nslope_detector;
  localparam int START = 24;
  localparam int HOLD  = 3;
  localparam int CMAX  = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse = 1'b0, gate = 1'b0, convert = 1'b0, fast = 1'b0, sense_low = 1'b0;
  logic full;

  int checks = 0, fails = 0, cyc = 0, fc = 0;
  bit m_vld = 0, m_full = 0;
  int m_peak = 0, m_run = 0, m_hold = 0;

  always #5 clk = ~clk;

  nslope_detector #(.START_CYC(START), .HOLD_SAMPLES(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse), .gate_i(gate),
    .convert_i(convert), .fast_i(fast), .sense_low_i(sense_low), .full_o(full)
  );

  // R3 arm-delay model
  always @(posedge clk) begin
    if (!rst_n || sense_low || !fast) fc <= 0;
    else if (fc < START) fc <= fc + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int sat(int n);
    return (n > CMAX) ? CMAX : n;
  endfunction

  function automatic bit is_drop(int s, int pk);
    return (pk - s) >= 2;
  endfunction

  task automatic check(bit got, bit exp, string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s full_o=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic clear_det_model();
    m_vld = 0; m_peak = 0; m_run = 0; m_hold = 0;
  endtask

  task automatic model_step(bit armed, int s);
    bit d;
    if (!armed) return;
    d = 0;
    if (!m_vld || s > m_peak) begin
      m_vld = 1; m_peak = s; m_run = 0;
    end else if (is_drop(s, m_peak)) begin
      d = 1;
      if (m_run >= 1 && m_hold >= HOLD) m_full = 1;
      m_run++;
    end else m_run = 0;
    if (m_hold < HOLD) m_hold++;
  endtask

  // enter and leave at a negedge
  task automatic smp(int n, int spur, string tag);
    bit armed;
    for (int i = 0; i < spur; i++) begin pulse = 1; gate = 0; @(negedge clk); end
    pulse = 0; gate = 1;
    for (int i = 0; i < n; i++) begin pulse = 1; @(negedge clk); end
    pulse = 0; @(negedge clk);
    gate = 0;  @(negedge clk);
    convert = 1; armed = (fc == START);
    @(negedge clk);
    convert = 0;
    model_step(armed, sat(n));
    check(full, m_full, tag);
  endtask

  task automatic arm();
    fast = 1;
    repeat (START + 1) @(negedge clk);
  endtask

  task automatic do_sense_low();
    sense_low = 1; @(negedge clk); sense_low = 0;
    clear_det_model(); m_full = 0;
    check(full, 1'b0, "R10 clear");
  endtask

  task automatic drop_fast();
    fast = 0; @(negedge clk);
    clear_det_model();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(full, 1'b0, "R1 reset");

    // R3: samples before arm are ignored, then R4/R5/R7/R9 persistent drop
    fast = 1;
    smp(8, 0, "R3 prearm");
    smp(8, 0, "R3 prearm");
    repeat (START) @(negedge clk);
    smp(100, 0, "R4 load");
    smp(100, 0, "R5 flat");
    smp(97, 0, "R7 drop in hold");
    smp(96, 0, "R9 fire after hold");
    smp(120, 0, "R9 latched");
    do_sense_low();

    // R8: drops during holdoff cancelled by rise; R5 one-count dip is not a drop
    arm();
    smp(200, 0, "R8 load");
    smp(190, 0, "R8 drop1");
    smp(185, 0, "R8 drop2 in hold");
    smp(201, 0, "R8 rise cancels");
    smp(200, 0, "R5 dip of 1");
    smp(200, 0, "R5 dip of 1");
    smp(199, 0, "R5 dip of 2");
    smp(198, 0, "R9 second drop");
    do_sense_low();

    // R2: saturation and stray pulses outside the gate
    arm();
    smp(1100, 40, "R2 saturate");
    smp(1100, 40, "R2 saturate");
    smp(1100, 40, "R2 saturate");
    smp(1022, 40, "R2 near max");
    smp(1021, 40, "R2 drop1");
    smp(1020, 40, "R2 drop2");
    do_sense_low();

    // R6: isolated drops never fire
    arm();
    for (int i = 0; i < 4; i++) smp(300, 0, "R6 fill hold");
    smp(297, 0, "R6 drop");
    smp(299, 0, "R6 flat clears");
    smp(297, 0, "R6 drop");
    smp(299, 0, "R6 flat clears");
    smp(296, 0, "R6 drop");
    smp(296, 0, "R9 adjacent drops");

    // R3: fast low keeps full, clears peak; re-arm with new level
    drop_fast();
    check(full, m_full, "R3 fast low keeps full");
    do_sense_low();
    arm();
    for (int i = 0; i < 4; i++) smp(150, 0, "R3 fill");
    smp(147, 0, "R3 drop1");
    drop_fast();
    arm();
    smp(140, 0, "R3 new load");
    smp(138, 0, "R3 drop in new hold");
    smp(137, 0, "R3 drop in new hold");
    smp(136, 0, "R3 fire after new hold");
    do_sense_low();

    // random walks
    for (int t = 0; t < 8; t++) begin
      int lvl;
      lvl = $urandom_range(150, 500);
      arm();
      for (int k = 0; k < 14; k++) begin
        int step;
        step = $urandom_range(0, 6) - ((t % 2 == 0) ? 4 : 3);
        lvl = lvl + step;
        if (lvl < 0) lvl = 0;
        smp(lvl, $urandom_range(0, 3), "R9 random");
      end
      if (t % 3 == 0) do_sense_low();
      else begin
        drop_fast();
        check(full, m_full, "R3 random fast low");
        do_sense_low();
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule